// File: doc/BRIEF.md
# BCD Time-of-Day Alarm with Repeat Masking

This block watches a running BCD time of day (seconds, minutes, hours, day of month) supplied by a separate timekeeper. It raises a one-clock interrupt pulse when that time agrees with four programmable alarm bytes. Bit 7 of each alarm byte is a "don't care" marker. The combination of the four markers picks a repeat period: once a month, once a day, once an hour, once a minute, or every second.

Software programs the block through a byte-wide register port with write and read strobes. Alarm writes whose BCD content is malformed or out of range are dropped, and the old byte is kept. A sticky flag records each alarm match and clears when it is read. A separate enable register gates the interrupt pulse but not the flag. Comparison happens only on the cycle in which the once-per-second tick input is high.

Top module: `bcd_alarm`

## Requirements
- R1: After reset, registers 0 to 5 all read 0x00. No flag is set and no pulse is produced until at least one alarm byte write has been accepted. Writing the enable register does not count as such a write.
- R2: The seconds alarm byte is at address 0. A write is accepted only if bits 3:0 hold a digit of 9 or less and bits 6:4 give a tens digit so that the value is 0 to 59. An accepted write stores all 8 bits, and reads return them. A rejected write leaves the old byte.
- R3: The minutes alarm byte is at address 1. It follows the same rule as R2: bits 6:0 must hold BCD 0 to 59.
- R4: The hours alarm byte is at address 2. A write is accepted only if bits 5:0 hold valid BCD 0 to 23. Otherwise it is dropped.
- R5: The date alarm byte is at address 3. A write is accepted only if bits 5:0 hold valid BCD digits whose value is not zero. Otherwise it is dropped.
- R6: The repeat mode comes from bit 7 of the date, hours, minutes and seconds bytes.
  - All four clear: compare all four fields (monthly).
  - Only date set: compare hours, minutes and seconds (daily).
  - Date and hours set: compare minutes and seconds (hourly).
  - Date, hours and minutes set: compare seconds only (per minute).
  - Any other combination: fire on every tick.
- R7: A match is evaluated only in a cycle where the tick input is high. The compared bits are 6:0 for seconds and minutes and 5:0 for hours and date, on both the alarm byte and the time input.
- R8: The flag register is at address 5, and bit 7 is the alarm flag. The flag is set by a match. It is cleared by a read of address 5. If a match and a clearing read happen in the same cycle, the set wins. Writes to address 5 are ignored.
- R9: The interrupt output is high for exactly one clock, in the cycle after the matching tick. It is high only when bit 7 of the enable register is set.
- R10: The enable register is at address 4. All 8 bits are writable and read back exactly as written.
- R11: Addresses 6 and 7 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effect only on the flag register) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from addr |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curDate | input | 8 | Current day of month, BCD |
| secTick | input | 1 | One-cycle pulse once per second |
| irqPulse | output | 1 | One-clock alarm interrupt |

## Verification
On every cycle, the assertions check several properties:
- The pulse lasts a single clock, follows a tick, and respects the enable bit.
- A pulse always comes with a set flag.
- The flag stays clear before the block is armed.
- A flag read clears the flag when no tick is present.
- A seconds write with a bad units digit leaves the register untouched.

Only the bench scenarios can show the rest:
- The exact acceptance boundaries of each field, swept over all 256 byte values.
- The mapping of all sixteen mask combinations onto compared fields.
- The set-over-clear priority and the readback of the enable and unmapped addresses.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

  localparam int BYTE_W      = 8;
  localparam int NUM_FIELDS  = 4;
  localparam int ADDR_W      = 3;
  localparam int FIELD_IDX_W = $clog2(NUM_FIELDS);
  localparam int MASK_BIT    = 7;
  localparam int FLAG_BIT    = 7;
  localparam int IEN_BIT     = 7;

  localparam logic [ADDR_W-1:0] ADDR_IEN  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(5);

  // field index: 0 seconds, 1 minutes, 2 hours, 3 date
  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MINUTE,
    RPT_SECOND
  } repeat_mode_t;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] wrField;
    logic                  wrIen;
    logic                  clrFlag;
    logic                  evalTick;
    logic [NUM_FIELDS-1:0] cmpSel;
  } ctrl_strobe_t;

  // bits of a byte that carry the time value for a field
  function automatic logic [BYTE_W-1:0] fieldMask(input int idx);
    logic [BYTE_W-1:0] m;
    m = (idx < 2) ? 8'h7F : 8'h3F;
    return m;
  endfunction

  // digit-level check of a BCD write against the field's legal range
  function automatic logic fieldValid(input int idx, input logic [BYTE_W-1:0] v);
    logic [3:0] units;
    logic [2:0] tens;
    logic       ok;
    units = v[3:0];
    tens  = (idx < 2) ? v[6:4] : {1'b0, v[5:4]};
    if (units > 4'd9) begin
      ok = 1'b0;
    end else begin
      case (idx)
        0, 1:    ok = (tens <= 3'd5);
        2:       ok = (tens < 3'd2) || ((tens == 3'd2) && (units <= 4'd3));
        default: ok = (tens != 3'd0) || (units != 4'd0);
      endcase
    end
    return ok;
  endfunction

  // which fields take part in the comparison for a repeat mode
  function automatic logic [NUM_FIELDS-1:0] modeCompare(input repeat_mode_t mode);
    logic [NUM_FIELDS-1:0] sel;
    case (mode)
      RPT_MONTH:  sel = 4'b1111;
      RPT_DAY:    sel = 4'b0111;
      RPT_HOUR:   sel = 4'b0011;
      RPT_MINUTE: sel = 4'b0001;
      default:    sel = 4'b0000;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/bcd_alarm_ctrl.sv
module bcd_alarm_ctrl
  import bcd_alarm_pkg::*;
(
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  secTick,
  input  logic [NUM_FIELDS-1:0] maskBits,
  output ctrl_strobe_t          strb,
  output repeat_mode_t          mode
);

  logic [NUM_FIELDS-1:0] fieldHit;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign fieldHit[i] = (addr == ADDR_W'(i));
  end

  // repeat mode from the four marker bits (bit 3 = date ... bit 0 = seconds)
  always_comb begin
    case (maskBits)
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end

  always_comb begin
    strb.wrField  = wrEn ? fieldHit : '0;
    strb.wrIen    = wrEn && (addr == ADDR_IEN);
    strb.clrFlag  = rdEn && (addr == ADDR_FLAG);
    strb.evalTick = secTick;
    strb.cmpSel   = modeCompare(mode);
  end

endmodule

// File: rtl/bcd_alarm_dp.sv
module bcd_alarm_dp
  import bcd_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobe_t          strb,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [BYTE_W-1:0]     curTime [NUM_FIELDS],
  output logic [NUM_FIELDS-1:0] maskBits,
  output logic [BYTE_W-1:0]     rdData,
  output logic                  irqPulse
);

  logic [BYTE_W-1:0]     alarmQ [NUM_FIELDS];
  logic [BYTE_W-1:0]     ienQ;
  logic                  flagQ;
  logic                  armedQ;
  logic                  pulseQ;
  logic [NUM_FIELDS-1:0] acceptVec;
  logic [NUM_FIELDS-1:0] fieldEq;
  logic                  matchNow;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [BYTE_W-1:0] FMASK = fieldMask(i);

    assign acceptVec[i] = strb.wrField[i] && fieldValid(i, wrData);
    assign fieldEq[i]   = ((alarmQ[i] & FMASK) == (curTime[i] & FMASK));
    assign maskBits[i]  = alarmQ[i][MASK_BIT];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        alarmQ[i] <= '0;
      end else if (acceptVec[i]) begin
        alarmQ[i] <= wrData;
      end
    end
  end

  assign matchNow = strb.evalTick && armedQ && (&(fieldEq | ~strb.cmpSel));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienQ   <= '0;
      armedQ <= 1'b0;
      flagQ  <= 1'b0;
      pulseQ <= 1'b0;
    end else begin
      if (strb.wrIen) ienQ <= wrData;
      if (|acceptVec) armedQ <= 1'b1;
      if (matchNow) flagQ <= 1'b1;
      else if (strb.clrFlag) flagQ <= 1'b0;
      pulseQ <= matchNow && ienQ[IEN_BIT];
    end
  end

  assign irqPulse = pulseQ;

  always_comb begin
    rdData = '0;
    if (addr < ADDR_W'(NUM_FIELDS)) begin
      rdData = alarmQ[addr[FIELD_IDX_W-1:0]];
    end else if (addr == ADDR_IEN) begin
      rdData = ienQ;
    end else if (addr == ADDR_FLAG) begin
      rdData[FLAG_BIT] = flagQ;
    end
  end

endmodule

// File: rtl/bcd_alarm.sv
module bcd_alarm
  import bcd_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic [BYTE_W-1:0] curSec,
  input  logic [BYTE_W-1:0] curMin,
  input  logic [BYTE_W-1:0] curHour,
  input  logic [BYTE_W-1:0] curDate,
  input  logic              secTick,
  output logic              irqPulse
);

  ctrl_strobe_t          strb;
  repeat_mode_t          mode;
  logic [NUM_FIELDS-1:0] maskBits;
  logic [BYTE_W-1:0]     curTime [NUM_FIELDS];

  assign curTime[0] = curSec;
  assign curTime[1] = curMin;
  assign curTime[2] = curHour;
  assign curTime[3] = curDate;

  bcd_alarm_ctrl u_ctrl (
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .secTick  (secTick),
    .maskBits (maskBits),
    .strb     (strb),
    .mode     (mode)
  );

  bcd_alarm_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .wrData   (wrData),
    .curTime  (curTime),
    .maskBits (maskBits),
    .rdData   (rdData),
    .irqPulse (irqPulse)
  );

endmodule

// File: rtl/bcd_alarm_chk.sv
module bcd_alarm_chk
  import bcd_alarm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wrData,
  input logic              secTick,
  input logic              irqPulse,
  input logic              ienBit,
  input logic              flagQ,
  input logic              armedQ,
  input logic [BYTE_W-1:0] secReg
);

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && !secTick) |=> !irqPulse);

  assert_pulse_after_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(secTick));

  assert_pulse_enabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(ienBit));

  assert_pulse_with_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> flagQ);

  assert_flag_read_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == ADDR_FLAG) && !secTick) |=> !flagQ);

  assert_quiet_unarmed_R1: assert property (@(posedge clk) disable iff (!rstN)
    !armedQ |-> (!flagQ && !irqPulse));

  assert_bad_sec_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == ADDR_W'(0)) && (wrData[3:0] > 4'd9)) |=> $stable(secReg));

endmodule

bind bcd_alarm bcd_alarm_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .addr     (addr),
  .wrData   (wrData),
  .secTick  (secTick),
  .irqPulse (irqPulse),
  .ienBit   (u_dp.ienQ[7]),
  .flagQ    (u_dp.flagQ),
  .armedQ   (u_dp.armedQ),
  .secReg   (u_dp.alarmQ[0])
);

// File: tb/test_bcd_alarm.sv
module test_bcd_alarm;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] curSec = '0, curMin = '0, curHour = '0, curDate = '0;
  logic       secTick = 1'b0;
  logic       irqPulse;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_alarm i_bcd_alarm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .curSec(curSec), .curMin(curMin),
    .curHour(curHour), .curDate(curDate), .secTick(secTick), .irqPulse(irqPulse)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] s, m, h, d);
    curSec = s; curMin = m; curHour = h; curDate = d;
  endtask

  // tick once; report the pulse one cycle later and the cycle after that
  task automatic doTick(output logic p0, output logic p1);
    @(negedge clk);
    secTick = 1'b1;
    @(posedge clk); #1 p0 = irqPulse;
    @(negedge clk);
    secTick = 1'b0;
    @(posedge clk); #1 p1 = irqPulse;
  endtask

  // arithmetic acceptance model: decimal value of the field within limits
  function automatic bit expValid(input int idx, input logic [7:0] v);
    int u, t, dec;
    u = v[3:0];
    t = (idx < 2) ? int'(v[6:4]) : int'(v[5:4]);
    dec = t * 10 + u;
    if (u > 9) return 1'b0;
    case (idx)
      0, 1: return dec <= 59;
      2:    return dec <= 23;
      default: return dec != 0;
    endcase
  endfunction

  function automatic logic [3:0] expCompare(input int m);
    case (m)
      0:  return 4'b1111;
      8:  return 4'b0111;
      12: return 4'b0011;
      14: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic p0, p1;
    logic [7:0] shadow [4];
    string tags [4];
    tags[0] = "R2"; tags[1] = "R3"; tags[2] = "R4"; tags[3] = "R5";

    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset contents
    for (int a = 0; a < 6; a++) begin
      doRead(3'(a), rd);
      check("R1 reset value", rd, 8'h00);
    end

    // R1: enable written, time all zero matches zeroed alarm, but not armed
    doWrite(3'd4, 8'h80);
    setTime(8'h00, 8'h00, 8'h00, 8'h00);
    doTick(p0, p1);
    check("R1 no pulse before arming", {7'b0, p0}, 8'h00);
    doRead(3'd5, rd);
    check("R1 no flag before arming", rd, 8'h00);

    // R10: enable register readback
    foreach (shadow[k]) shadow[k] = 8'h00;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v;
      v = (k == 0) ? 8'hA5 : (k == 1) ? 8'h5A : (k == 2) ? 8'hFF : 8'h00;
      doWrite(3'd4, v);
      doRead(3'd4, rd);
      check("R10 enable readback", rd, v);
    end

    // R2..R5: sweep every byte value into every alarm field
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < 256; v++) begin
        doWrite(3'(f), 8'(v));
        if (expValid(f, 8'(v))) shadow[f] = 8'(v);
        doRead(3'(f), rd);
        check(tags[f], rd, shadow[f]);
      end
    end

    // R11: unmapped addresses and flag write ignored
    doWrite(3'd6, 8'hFF);
    doRead(3'd6, rd); check("R11 addr 6", rd, 8'h00);
    doWrite(3'd7, 8'hFF);
    doRead(3'd7, rd); check("R11 addr 7", rd, 8'h00);
    doRead(3'd5, rd);
    doWrite(3'd5, 8'h80);
    doRead(3'd5, rd); check("R8 flag write ignored", rd, 8'h00);
    for (int f = 0; f < 4; f++) begin
      doRead(3'(f), rd); check("R11 alarm untouched", rd, shadow[f]);
    end

    // R6/R7/R8/R9: all sixteen mask combinations, five time patterns
    doWrite(3'd4, 8'h80);
    for (int m = 0; m < 16; m++) begin
      logic [3:0] cmp;
      cmp = expCompare(m);
      doWrite(3'd0, 8'h30 | (m[0] ? 8'h80 : 8'h00));
      doWrite(3'd1, 8'h15 | (m[1] ? 8'h80 : 8'h00));
      doWrite(3'd2, 8'h12 | (m[2] ? 8'h80 : 8'h00));
      doWrite(3'd3, 8'h21 | (m[3] ? 8'h80 : 8'h00));
      doRead(3'd5, rd);
      for (int p = 0; p < 5; p++) begin
        bit fire;
        setTime(p == 1 ? 8'h31 : 8'h30, p == 2 ? 8'h16 : 8'h15,
                p == 3 ? 8'h13 : 8'h12, p == 4 ? 8'h22 : 8'h21);
        fire = (p == 0) || !cmp[p-1];
        doTick(p0, p1);
        check("R6 repeat mode pulse", {7'b0, p0}, {7'b0, fire});
        check("R9 single cycle pulse", {7'b0, p1}, 8'h00);
        doRead(3'd5, rd);
        check("R8 flag after tick", rd, fire ? 8'h80 : 8'h00);
        doRead(3'd5, rd);
        check("R8 flag cleared by read", rd, 8'h00);
      end
    end

    // R7: matching time without tick sets nothing (monthly mode, exact match)
    doWrite(3'd0, 8'h30); doWrite(3'd1, 8'h15);
    doWrite(3'd2, 8'h12); doWrite(3'd3, 8'h21);
    setTime(8'h30, 8'h15, 8'h12, 8'h21);
    repeat (5) @(negedge clk);
    check("R7 no pulse without tick", {7'b0, irqPulse}, 8'h00);
    doRead(3'd5, rd);
    check("R7 no flag without tick", rd, 8'h00);

    // R7: bit 7 of time input ignored in compare
    setTime(8'hB0, 8'h95, 8'h52, 8'h61);
    doTick(p0, p1);
    check("R7 upper bits ignored", {7'b0, p0}, 8'h01);
    doRead(3'd5, rd);

    // R9: enable off, flag still set, no pulse
    doWrite(3'd4, 8'h7F);
    setTime(8'h30, 8'h15, 8'h12, 8'h21);
    doTick(p0, p1);
    check("R9 pulse gated by enable", {7'b0, p0}, 8'h00);
    doRead(3'd5, rd);
    check("R9 flag despite disabled pulse", rd, 8'h80);

    // R8: set wins over a clearing read in the same cycle
    doRead(3'd5, rd);
    @(negedge clk);
    rdEn = 1'b1; addr = 3'd5; secTick = 1'b1;
    #1 rd = rdData;
    check("R8 old flag during read", rd, 8'h00);
    @(negedge clk);
    rdEn = 1'b0; secTick = 1'b0;
    doRead(3'd5, rd);
    check("R8 set wins over clear", rd, 8'h80);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule